// File: doc/BRIEF.md
# Interrupt-Capable 32-Pin GPIO Bank

This block is a single bank of 32 general-purpose pins, controlled through a flat 32-bit register bus. The bus has a byte address, a write strobe, write data and combinational read data. Software sets the output value and the direction of each pin. It reads back the pad levels after a two-flop synchroniser.

Each pin can raise an interrupt. Three separate per-pin bits choose how it is sensed: level or edge, a both-edges override, and a polarity that means rising/high when 1 and falling/low when 0. Detected events collect in a sticky raw status word. A mask word selects which pins reach the single interrupt line. A masked view of the status can be read back, and software acknowledges pins by writing ones to a clear word.

The bank also holds the pull-resistor settings and a 3-bit drive-strength code for each pin. These are plain storage that drives the pad control outputs directly.

Top module: `pin_bank_ctrl`

## Requirements
- R1: After reset every register reads 0. All pins are inputs (`pad_oe` = 0), `pad_out`, the pull outputs, `pad_drv` and `irq_out` are 0, and every interrupt is masked.
- R2: Offset 0x04 holds the output value and 0x08 the output enable (1 = drive), and both read back as written. `pad_oe` equals the enable word. `pad_out` bit n equals the output value bit n when enable bit n is 1, and 0 otherwise.
- R3: Reading offset 0x00 returns `pad_in` after two register stages. A pad change is not visible one clock after it is applied, and is visible two clocks after.
- R4: Level mode is selected by a 1 in offset 0x0C. With polarity (offset 0x14) at 1 a high pin sets its status bit, and with polarity at 0 a low pin does. The bit is set again on every clock while the level holds, so a clear does not remove it.
- R5: Edge mode is selected by a 0 in offset 0x0C, with the both-edges bit (offset 0x10) at 0. Polarity 1 records only rising transitions and polarity 0 only falling ones. The opposite transition leaves the status unchanged. A transition is a change of the synchronised value from one clock to the next.
- R6: In edge mode, a 1 in the both-edges bit records rising and falling transitions whatever the polarity bit holds.
- R7: Raw status (offset 0x1C) holds every detected event until it is cleared, whatever the mask says. The mask lives at offset 0x18 (1 = enabled). The masked status (offset 0x20) reads as raw status AND mask.
- R8: Writing 1 to bit n of offset 0x24 clears raw status bit n, and a 0 bit leaves it unchanged. An event on the same clock as the clear wins, and the bit stays set. Offset 0x24 reads as 0.
- R9: `irq_out` is 1 exactly when at least one pin has both its raw status bit and its mask bit set.
- R10: Pull enable (offset 0x38) drives `pad_pull_en`, and pull select (offset 0x34, 1 = up, 0 = down) drives `pad_pull_up`. Both read back as written.
- R11: The drive code for pin n is 3 bits, equal to mA/2 − 1. Bit k of the code is stored in bit n of the plane at offset 0x58 + 4k (planes at 0x58, 0x5C, 0x60). Plane k is output on `pad_drv[32k+n]`, and each plane reads back as written.
- R12: Writes to the read-only offsets 0x00, 0x1C and 0x20 have no effect. Any unlisted offset reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pad_in | input | 32 | Pad input levels (asynchronous) |
| pad_out | output | 32 | Pad output values, gated by the enable |
| pad_oe | output | 32 | Pad output enables |
| pad_pull_en | output | 32 | Pull resistor enable per pin |
| pad_pull_up | output | 32 | Pull direction per pin, 1 = up |
| pad_drv | output | 96 | Drive-strength code planes, plane k at [32k +: 32] |
| irq_out | output | 1 | OR of all masked status bits |

## Verification
The hardest case to reach is a clear write and a fresh edge event landing on the same clock. The event reaches status three clocks after the pad change, because of the two synchroniser stages and the previous-value register. The bench therefore changes the pin and waits exactly two clocks. It then issues the clear write so that the strobe is sampled on the edge where the event is registered, and reads the raw status back as still set. The level re-arm case, where a clear is immediately overridden while the level holds, and the both-edges override with polarity set the other way, are reached by reprogramming the sense bits between pin toggles.

// File: rtl/pbk_pkg.sv
package pbk_pkg;
    parameter int PBK_PINS     = 32;
    parameter int PBK_DRV_BITS = 3;
    parameter int PBK_ADDR_W   = 8;

    localparam logic [7:0] OFF_DIN    = 8'h00;
    localparam logic [7:0] OFF_DOUT   = 8'h04;
    localparam logic [7:0] OFF_OE     = 8'h08;
    localparam logic [7:0] OFF_LVL    = 8'h0C;
    localparam logic [7:0] OFF_DUAL   = 8'h10;
    localparam logic [7:0] OFF_POL    = 8'h14;
    localparam logic [7:0] OFF_MASK   = 8'h18;
    localparam logic [7:0] OFF_RAW    = 8'h1C;
    localparam logic [7:0] OFF_MST    = 8'h20;
    localparam logic [7:0] OFF_CLR    = 8'h24;
    localparam logic [7:0] OFF_PSEL   = 8'h34;
    localparam logic [7:0] OFF_PEN    = 8'h38;
    localparam logic [7:0] OFF_DRV0   = 8'h58;
    localparam int         DRV_STRIDE = 4;

    function automatic logic [7:0] drv_plane_off(input int plane);
        return OFF_DRV0 + 8'(plane * DRV_STRIDE);
    endfunction
endpackage

// File: rtl/pbk_sync.sv
module pbk_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pbk_sense.sv
module pbk_sense #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] s_i,
    input  logic [WIDTH-1:0] lvl_i,
    input  logic [WIDTH-1:0] dual_i,
    input  logic [WIDTH-1:0] pol_i,
    output logic [WIDTH-1:0] evt_o
);
    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb prev_d = s_i;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar g = 0; g < WIDTH; g++) begin : g_pin
        logic rise, fall;
        always_comb begin
            rise = s_i[g] & ~prev_q[g];
            fall = ~s_i[g] & prev_q[g];
            if (lvl_i[g])       evt_o[g] = pol_i[g] ? s_i[g] : ~s_i[g];
            else if (dual_i[g]) evt_o[g] = rise | fall;
            else                evt_o[g] = pol_i[g] ? rise : fall;
        end
    end
endmodule

// File: rtl/pbk_status.sv
module pbk_status #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] evt_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] st_o
);
    logic [WIDTH-1:0] st_d, st_q;

    always_comb st_d = (st_q & ~clr_i) | evt_i;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st_o = st_q;

    // R7
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(st_q) & ~$past(clr_i)) & ~st_q) == '0));

    // R8
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q & $past(clr_i & ~evt_i)) == '0));
endmodule

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl
    import pbk_pkg::*;
#(
    parameter int NPINS    = PBK_PINS,
    parameter int DRV_BITS = PBK_DRV_BITS,
    parameter int ADDR_W   = PBK_ADDR_W,
    parameter int SYNC_STG = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_we,
    input  logic [NPINS-1:0]          bus_wdata,
    output logic [NPINS-1:0]          bus_rdata,
    input  logic [NPINS-1:0]          pad_in,
    output logic [NPINS-1:0]          pad_out,
    output logic [NPINS-1:0]          pad_oe,
    output logic [NPINS-1:0]          pad_pull_en,
    output logic [NPINS-1:0]          pad_pull_up,
    output logic [DRV_BITS*NPINS-1:0] pad_drv,
    output logic                      irq_out
);
    localparam int DRV_W = DRV_BITS * NPINS;

    typedef struct packed {
        logic [NPINS-1:0]                dout;
        logic [NPINS-1:0]                oe;
        logic [NPINS-1:0]                lvl;
        logic [NPINS-1:0]                dual;
        logic [NPINS-1:0]                pol;
        logic [NPINS-1:0]                mask;
        logic [NPINS-1:0]                psel;
        logic [NPINS-1:0]                pen;
        logic [DRV_BITS-1:0][NPINS-1:0]  drv;
    } cfg_t;

    cfg_t             cfg_d, cfg_q;
    logic [NPINS-1:0] sync_s;
    logic [NPINS-1:0] evt;
    logic [NPINS-1:0] clr_pulse;
    logic [NPINS-1:0] raw_st;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
        return a == ADDR_W'(off);
    endfunction

    pbk_sync #(.WIDTH(NPINS), .STAGES(SYNC_STG)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d_i (pad_in),
        .q_o (sync_s)
    );

    pbk_sense #(.WIDTH(NPINS)) u_sense (
        .clk    (clk),
        .rst_n  (rst_n),
        .s_i    (sync_s),
        .lvl_i  (cfg_q.lvl),
        .dual_i (cfg_q.dual),
        .pol_i  (cfg_q.pol),
        .evt_o  (evt)
    );

    pbk_status #(.WIDTH(NPINS)) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (evt),
        .clr_i (clr_pulse),
        .st_o  (raw_st)
    );

    // register write path
    always_comb begin
        cfg_d     = cfg_q;
        clr_pulse = '0;
        if (bus_we) begin
            if (hit(bus_addr, OFF_DOUT)) cfg_d.dout = bus_wdata;
            if (hit(bus_addr, OFF_OE))   cfg_d.oe   = bus_wdata;
            if (hit(bus_addr, OFF_LVL))  cfg_d.lvl  = bus_wdata;
            if (hit(bus_addr, OFF_DUAL)) cfg_d.dual = bus_wdata;
            if (hit(bus_addr, OFF_POL))  cfg_d.pol  = bus_wdata;
            if (hit(bus_addr, OFF_MASK)) cfg_d.mask = bus_wdata;
            if (hit(bus_addr, OFF_PSEL)) cfg_d.psel = bus_wdata;
            if (hit(bus_addr, OFF_PEN))  cfg_d.pen  = bus_wdata;
            if (hit(bus_addr, OFF_CLR))  clr_pulse  = bus_wdata;
            for (int p = 0; p < DRV_BITS; p++) begin
                if (hit(bus_addr, drv_plane_off(p))) cfg_d.drv[p] = bus_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    // register read path
    always_comb begin
        bus_rdata = '0;
        if (hit(bus_addr, OFF_DIN))  bus_rdata = sync_s;
        if (hit(bus_addr, OFF_DOUT)) bus_rdata = cfg_q.dout;
        if (hit(bus_addr, OFF_OE))   bus_rdata = cfg_q.oe;
        if (hit(bus_addr, OFF_LVL))  bus_rdata = cfg_q.lvl;
        if (hit(bus_addr, OFF_DUAL)) bus_rdata = cfg_q.dual;
        if (hit(bus_addr, OFF_POL))  bus_rdata = cfg_q.pol;
        if (hit(bus_addr, OFF_MASK)) bus_rdata = cfg_q.mask;
        if (hit(bus_addr, OFF_RAW))  bus_rdata = raw_st;
        if (hit(bus_addr, OFF_MST))  bus_rdata = raw_st & cfg_q.mask;
        if (hit(bus_addr, OFF_PSEL)) bus_rdata = cfg_q.psel;
        if (hit(bus_addr, OFF_PEN))  bus_rdata = cfg_q.pen;
        for (int p = 0; p < DRV_BITS; p++) begin
            if (hit(bus_addr, drv_plane_off(p))) bus_rdata = cfg_q.drv[p];
        end
    end

    // pad side
    assign pad_oe      = cfg_q.oe;
    assign pad_out     = cfg_q.dout & cfg_q.oe;
    assign pad_pull_en = cfg_q.pen;
    assign pad_pull_up = cfg_q.psel;
    assign pad_drv     = DRV_W'(cfg_q.drv);
    assign irq_out     = |(raw_st & cfg_q.mask);

    // R2
    dout_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit(bus_addr, OFF_DOUT)) |=> ((pad_out & pad_oe) == ($past(bus_wdata) & pad_oe)));

    // R4
    level_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(cfg_q.lvl & cfg_q.pol & sync_s) |
                    $past(cfg_q.lvl & ~cfg_q.pol & ~sync_s)) & ~raw_st) == '0));

    // R5
    edge_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((raw_st & ~$past(raw_st)) & ~$past(cfg_q.lvl) &
                   ~($past(sync_s) ^ $past(sync_s, 2))) == '0));

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit(bus_addr, OFF_MASK) && bus_wdata == '0) |=> !irq_out);
endmodule

// File: tb/sim_pin_bank_ctrl.sv
module sim_pin_bank_ctrl;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe, pad_pull_en, pad_pull_up;
    logic [95:0] pad_drv;
    logic        irq_out;

    pin_bank_ctrl u0 (
        .clk (clk), .rst_n (rst_n),
        .bus_addr (bus_addr), .bus_we (bus_we), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .pad_in (pad_in), .pad_out (pad_out), .pad_oe (pad_oe),
        .pad_pull_en (pad_pull_en), .pad_pull_up (pad_pull_up),
        .pad_drv (pad_drv), .irq_out (irq_out)
    );

    always #(CLK_P/2) clk = ~clk;

    typedef enum int { SRC_RD, SRC_OUT, SRC_OE, SRC_PEN, SRC_PUP, SRC_DRV0, SRC_DRV1, SRC_DRV2, SRC_IRQ } src_e;
    typedef struct { src_e src; logic [31:0] exp; string tag; } item_t;
    item_t sb[$];

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    function automatic logic [31:0] observe(src_e s);
        case (s)
            SRC_RD:   return bus_rdata;
            SRC_OUT:  return pad_out;
            SRC_OE:   return pad_oe;
            SRC_PEN:  return pad_pull_en;
            SRC_PUP:  return pad_pull_up;
            SRC_DRV0: return pad_drv[31:0];
            SRC_DRV1: return pad_drv[63:32];
            SRC_DRV2: return pad_drv[95:64];
            default:  return {31'd0, irq_out};
        endcase
    endfunction

    // monitor: samples a quarter period after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                act = observe(it.src);
                n_chk++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: src %s actual %h expected %h", it.tag, it.src.name(), act, it.exp);
                end
            end
        end
    end

    // driver tasks: entered and left on a falling edge
    task automatic chk(src_e s, logic [31:0] e, string tag);
        item_t it;
        it.src = s; it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
        bus_addr = a;
        chk(SRC_RD, e, tag);
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic pins(logic [31:0] v);
        pad_in = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h04, 32'h0, "R1");
        rd(8'h08, 32'h0, "R1");
        rd(8'h18, 32'h0, "R1");
        rd(8'h1C, 32'h0, "R1");
        chk(SRC_OE, 32'h0, "R1");
        chk(SRC_IRQ, 32'h0, "R1");
        chk(SRC_DRV2, 32'h0, "R1");
        @(negedge clk);

        // R2 output path
        wr(8'h04, 32'hA5A5_0F0F);
        rd(8'h04, 32'hA5A5_0F0F, "R2");
        chk(SRC_OUT, 32'h0, "R2");
        wr(8'h08, 32'hFFFF_0000);
        chk(SRC_OUT, 32'hA5A5_0000, "R2");
        chk(SRC_OE, 32'hFFFF_0000, "R2");
        rd(8'h08, 32'hFFFF_0000, "R2");

        // R12 read-only / unmapped
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, 32'h0, "R12");
        rd(8'h30, 32'h0, "R12");
        rd(8'h24, 32'h0, "R8");

        // R3 synchroniser latency; R5 rising edges ignored in falling mode
        pad_in = 32'h1234_5678;
        @(negedge clk);
        rd(8'h00, 32'h0, "R3");
        rd(8'h00, 32'h1234_5678, "R3");
        rd(8'h1C, 32'h0, "R5");
        pins(32'h0);
        rd(8'h1C, 32'h1234_5678, "R7");
        rd(8'h20, 32'h0, "R7");
        chk(SRC_IRQ, 32'h0, "R9");
        wr(8'h24, 32'h0000_FFFF);
        rd(8'h1C, 32'h1234_0000, "R8");
        wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h1C, 32'h0, "R8");

        // R5 rising edge on pin 0
        wr(8'h14, 32'h1);
        wr(8'h18, 32'h1);
        pins(32'h1);
        rd(8'h1C, 32'h1, "R5");
        rd(8'h20, 32'h1, "R7");
        chk(SRC_IRQ, 32'h1, "R9");
        wr(8'h24, 32'h1);
        chk(SRC_IRQ, 32'h0, "R9");
        pins(32'h0);
        rd(8'h1C, 32'h0, "R5");

        // R6 both edges on pin 1, polarity says rising
        wr(8'h14, 32'h3);
        wr(8'h10, 32'h2);
        wr(8'h18, 32'h3);
        pins(32'h2);
        rd(8'h1C, 32'h2, "R6");
        wr(8'h24, 32'h2);
        rd(8'h1C, 32'h0, "R6");
        pins(32'h0);
        rd(8'h1C, 32'h2, "R6");
        wr(8'h24, 32'h2);

        // R4 level high on pin 2
        wr(8'h14, 32'h7);
        wr(8'h0C, 32'h4);
        wr(8'h18, 32'h7);
        pins(32'h4);
        rd(8'h1C, 32'h4, "R4");
        chk(SRC_IRQ, 32'h1, "R9");
        wr(8'h24, 32'h4);
        rd(8'h1C, 32'h4, "R4");
        pins(32'h0);
        rd(8'h1C, 32'h4, "R7");
        wr(8'h24, 32'h4);
        rd(8'h1C, 32'h0, "R4");
        // R4 level low on pin 2
        wr(8'h14, 32'h3);
        @(negedge clk);
        rd(8'h1C, 32'h4, "R4");
        wr(8'h0C, 32'h0);
        wr(8'h24, 32'h4);
        rd(8'h1C, 32'h0, "R4");

        // R8 clear and new edge on the same clock (pin 3, masked off)
        wr(8'h14, 32'h8);
        pad_in = 32'h8;
        repeat (2) @(negedge clk);
        wr(8'h24, 32'h8);
        rd(8'h1C, 32'h8, "R8");
        rd(8'h20, 32'h0, "R7");
        chk(SRC_IRQ, 32'h0, "R9");
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h1C, 32'h8, "R12");
        wr(8'h24, 32'h8);
        rd(8'h1C, 32'h0, "R8");

        // R10 pulls
        wr(8'h38, 32'h0000_00F0);
        wr(8'h34, 32'h0000_0030);
        chk(SRC_PEN, 32'h0000_00F0, "R10");
        chk(SRC_PUP, 32'h0000_0030, "R10");
        rd(8'h34, 32'h0000_0030, "R10");

        // R11 drive code 3 (8 mA) on pin 5
        wr(8'h58, 32'h20);
        wr(8'h5C, 32'h20);
        chk(SRC_DRV0, 32'h20, "R11");
        chk(SRC_DRV1, 32'h20, "R11");
        chk(SRC_DRV2, 32'h0, "R11");
        rd(8'h5C, 32'h20, "R11");
        rd(8'h64, 32'h0, "R12");

        repeat (2) @(negedge clk);
        done = 1'b1;
        finish_run();
    end
endmodule